// File: doc/BRIEF.md
# Capacitive Pixel Array Scan Timing Generator

This block drives the readout of a 192-column by 128-row capacitive pixel array from one main clock. An active-low start input clears the sequencer and begins a frame. The frame opens with one setup clock and two read-only line slots. After that, one line slot per row follows, and each slot has 192 pixel-output clocks and then 64 sense clocks. The block produces a column strobe per pixel and a row strobe per row. It also drives a sense-phase flag, a pixel-valid flag with zero-based row and column indices, and last-column and last-row indicators. A one-clock done pulse ends the frame.

The gain code for the sense amplifiers is latched when the start input is low, so it stays fixed for the whole frame. A power-save input freezes the sequence where it stands until it is released. A start pulse in the middle of a frame abandons that frame and begins again from clock 0.

Top module: `scan_tgen`

## Requirements
- R1: While reset is active, and after it is released with start_n high, every output is low and `gain_out` is 0.
- R2: A clock edge that samples `start_n` low clears the sequence, so the next clock is frame clock 0. While `start_n` is low, `pix_valid`, `sense_ph` and every strobe stay low.
- R3: `gain_out` takes the value of `gain_in` (bit 0 is the LSB) at each edge that samples `start_n` low. At any other time `gain_in` has no effect on `gain_out`.
- R4: Frame clock 0 is a setup clock and frame clocks 1 to 512 form two read-only slots, so the first pixel (row 0, column 0) appears on frame clock 513.
- R5: Pixel (row r, column c) is presented on frame clock 513 + 256·r + c, with `pix_valid` high, `row_idx` = r and `col_idx` = c, both zero-based. The order is row-major. Outside pixel clocks both indices read 0.
- R6: `sense_ph` is high on slot offsets 192 to 255 of every slot, the two read-only slots included, where slot offset = (frame clock − 1) mod 256 for frame clocks from 1 upward.
- R7: `col_adv` is high on every pixel clock. `row_adv` is high on the column-0 pixel clock of each row.
- R8: `col_last` is high on the column-191 pixel clock of each row. `row_last` is high on the `row_adv` clock of row 127.
- R9: A frame lasts 33281 clocks (frame clocks 0 to 33280). `frame_done` is high on frame clock 33280, and the block then idles with all outputs low until the next start.
- R10: While `pwr_save` is high, the frame clock does not advance and every strobe (`row_adv`, `col_adv`, `col_last`, `row_last`, `frame_done`) is low. `pix_valid`, `sense_ph` and the indices hold their values.
- R11: A start pulse in the middle of a frame abandons it. The following frame starts again at clock 0, with its first pixel on frame clock 513 and the newly latched gain.
- R12: A start sampled while `pwr_save` is high still clears the sequence and latches the gain. Frame clocks then count only the clocks with `pwr_save` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low frame start and clear |
| pwr_save | input | 1 | High freezes the sequence |
| gain_in | input | 3 | Gain code sampled at start |
| row_adv | output | 1 | Row advance strobe |
| col_adv | output | 1 | Column advance strobe, one per pixel |
| sense_ph | output | 1 | Sense portion of the current slot |
| pix_valid | output | 1 | Analog output carries a pixel |
| row_idx | output | 7 | Zero-based row of the current pixel |
| col_idx | output | 8 | Zero-based column of the current pixel |
| gain_out | output | 3 | Gain code latched for this frame |
| row_last | output | 1 | Last row is starting |
| col_last | output | 1 | Last column of a row |
| frame_done | output | 1 | Last clock of the frame |

## Verification
One frame runs with `pwr_save` held low and a new random `gain_in` on every clock. This pins down the plain schedule (first pixel, line pitch, frame length) and shows that the gain only moves at start. A second frame runs with random `pwr_save` bursts. This separates a sequencer that really freezes from one that only masks its strobes, because every later pixel would then land on the wrong clock. Directed cases follow: a restart in the middle of a frame, and a start issued during power-save. These tell correct clearing and priority apart from a design that resumes the old position or drops the start.

// File: rtl/sg_pkg.sv
package sg_pkg;

  // clocks in one line slot: pixel output followed by sense
  function automatic int line_len(input int cols, input int reads);
    return cols + reads;
  endfunction

  // frame clock on which the first pixel is presented
  function automatic int first_pix(input int cols, input int reads, input int lead);
    return 1 + lead * line_len(cols, reads);
  endfunction

  // total clocks from frame clock 0 through the last sense clock
  function automatic int frame_len(input int cols, input int reads, input int rows,
                                   input int lead);
    return first_pix(cols, reads, lead) + rows * line_len(cols, reads);
  endfunction

endpackage

// File: rtl/sg_frame_ctl.sv
module sg_frame_ctl #(
  parameter int FRAME  = 33281,
  parameter int GAIN_W = 3,
  parameter int TW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n,
  input  logic              pwr_save,
  input  logic [GAIN_W-1:0] gain_in,
  output logic              run,
  output logic [TW-1:0]     tcnt,
  output logic [GAIN_W-1:0] gain_q,
  output logic              adv,
  output logic              last_clk
);

  // one frame clock is consumed only when running, not clearing, not frozen
  assign adv      = run & start_n & ~pwr_save;
  assign last_clk = run && (tcnt == TW'(FRAME - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      tcnt   <= '0;
      gain_q <= '0;
    end else if (!start_n) begin
      run    <= 1'b1;
      tcnt   <= '0;
      gain_q <= gain_in;
    end else if (adv) begin
      if (last_clk) begin
        run  <= 1'b0;
        tcnt <= '0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sg_line_timer.sv
module sg_line_timer #(
  parameter int LINE = 256,
  parameter int OW   = 8,
  parameter int SW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic          armed,
  output logic [OW-1:0] off,
  output logic [SW-1:0] slot
);

  logic line_wrap;
  assign line_wrap = (off == OW'(LINE - 1));

  // armed is low only on the setup clock; then offset and slot walk the frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      off   <= '0;
      slot  <= '0;
    end else if (clr) begin
      armed <= 1'b0;
      off   <= '0;
      slot  <= '0;
    end else if (adv) begin
      if (!armed) begin
        armed <= 1'b1;
      end else if (line_wrap) begin
        off  <= '0;
        slot <= slot + 1'b1;
      end else begin
        off  <= off + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sg_out_decode.sv
module sg_out_decode #(
  parameter int COLS       = 192,
  parameter int ROWS       = 128,
  parameter int LEAD_SLOTS = 2,
  parameter int OW         = 8,
  parameter int SW         = 8,
  parameter int RW         = 7,
  parameter int CW         = 8
) (
  input  logic          run,
  input  logic          start_n,
  input  logic          pwr_save,
  input  logic          armed,
  input  logic [OW-1:0] off,
  input  logic [SW-1:0] slot,
  input  logic          last_clk,
  output logic          row_adv,
  output logic          col_adv,
  output logic          sense_ph,
  output logic          pix_valid,
  output logic [RW-1:0] row_idx,
  output logic [CW-1:0] col_idx,
  output logic          row_last,
  output logic          col_last,
  output logic          frame_done
);

  logic act, out_slot, out_part, pv, stb_en, first_col, final_col, final_row;

  assign act       = run & start_n;
  assign stb_en    = ~pwr_save;
  assign out_slot  = armed && (slot >= SW'(LEAD_SLOTS)) && (slot < SW'(LEAD_SLOTS + ROWS));
  assign out_part  = (off < OW'(COLS));
  assign pv        = act && out_slot && out_part;
  assign first_col = (off == '0);
  assign final_col = (off == OW'(COLS - 1));
  assign final_row = (slot == SW'(LEAD_SLOTS + ROWS - 1));

  always_comb begin
    pix_valid  = pv;
    sense_ph   = act && armed && !out_part;
    row_idx    = pv ? RW'(slot - SW'(LEAD_SLOTS)) : '0;
    col_idx    = pv ? CW'(off) : '0;
    col_adv    = pv && stb_en;
    row_adv    = pv && stb_en && first_col;
    col_last   = pv && stb_en && final_col;
    row_last   = pv && stb_en && first_col && final_row;
    frame_done = act && stb_en && last_clk;
  end

endmodule

// File: rtl/scan_tgen.sv
module scan_tgen
  import sg_pkg::*;
#(
  parameter int COLS       = 192,
  parameter int ROWS       = 128,
  parameter int READ_CLKS  = 64,
  parameter int LEAD_SLOTS = 2,
  parameter int GAIN_W     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_n,
  input  logic                     pwr_save,
  input  logic [GAIN_W-1:0]        gain_in,
  output logic                     row_adv,
  output logic                     col_adv,
  output logic                     sense_ph,
  output logic                     pix_valid,
  output logic [$clog2(ROWS)-1:0]  row_idx,
  output logic [$clog2(COLS)-1:0]  col_idx,
  output logic [GAIN_W-1:0]        gain_out,
  output logic                     row_last,
  output logic                     col_last,
  output logic                     frame_done
);

  localparam int LINE  = line_len(COLS, READ_CLKS);
  localparam int FRAME = frame_len(COLS, READ_CLKS, ROWS, LEAD_SLOTS);
  localparam int SLOTS = ROWS + LEAD_SLOTS;
  localparam int TW    = $clog2(FRAME);
  localparam int OW    = $clog2(LINE);
  localparam int SW    = $clog2(SLOTS + 1);
  localparam int RW    = $clog2(ROWS);
  localparam int CW    = $clog2(COLS);

  // named internal events, also observed by the bound checker
  logic              run_w, adv_w, last_w, armed_w;
  logic [TW-1:0]     tcnt_w;
  logic [OW-1:0]     off_w;
  logic [SW-1:0]     slot_w;
  logic [GAIN_W-1:0] gain_q;

  sg_frame_ctl #(.FRAME(FRAME), .GAIN_W(GAIN_W), .TW(TW)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_n  (start_n),
    .pwr_save (pwr_save),
    .gain_in  (gain_in),
    .run      (run_w),
    .tcnt     (tcnt_w),
    .gain_q   (gain_q),
    .adv      (adv_w),
    .last_clk (last_w)
  );

  sg_line_timer #(.LINE(LINE), .OW(OW), .SW(SW)) u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~start_n),
    .adv   (adv_w),
    .armed (armed_w),
    .off   (off_w),
    .slot  (slot_w)
  );

  sg_out_decode #(
    .COLS(COLS), .ROWS(ROWS), .LEAD_SLOTS(LEAD_SLOTS),
    .OW(OW), .SW(SW), .RW(RW), .CW(CW)
  ) u_dec (
    .run        (run_w),
    .start_n    (start_n),
    .pwr_save   (pwr_save),
    .armed      (armed_w),
    .off        (off_w),
    .slot       (slot_w),
    .last_clk   (last_w),
    .row_adv    (row_adv),
    .col_adv    (col_adv),
    .sense_ph   (sense_ph),
    .pix_valid  (pix_valid),
    .row_idx    (row_idx),
    .col_idx    (col_idx),
    .row_last   (row_last),
    .col_last   (col_last),
    .frame_done (frame_done)
  );

  assign gain_out = gain_q;

endmodule

// File: rtl/sg_scan_chk.sv
module sg_scan_chk
  import sg_pkg::*;
#(
  parameter int COLS       = 192,
  parameter int ROWS       = 128,
  parameter int READ_CLKS  = 64,
  parameter int LEAD_SLOTS = 2,
  parameter int GAIN_W     = 3,
  parameter int TW         = 16,
  parameter int OW         = 8,
  parameter int SW         = 8,
  parameter int RW         = 7,
  parameter int CW         = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_n,
  input logic              pwr_save,
  input logic              row_adv,
  input logic              col_adv,
  input logic              pix_valid,
  input logic [RW-1:0]     row_idx,
  input logic [CW-1:0]     col_idx,
  input logic [GAIN_W-1:0] gain_out,
  input logic              row_last,
  input logic              col_last,
  input logic              frame_done,
  input logic              run_w,
  input logic [TW-1:0]     tcnt_w,
  input logic              armed_w,
  input logic [OW-1:0]     off_w,
  input logic [SW-1:0]     slot_w
);

  localparam int LINE  = line_len(COLS, READ_CLKS);
  localparam int FRAME = frame_len(COLS, READ_CLKS, ROWS, LEAD_SLOTS);
  localparam int FIRST = first_pix(COLS, READ_CLKS, LEAD_SLOTS);
  localparam int SLOTS = ROWS + LEAD_SLOTS;

  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start_n |=> (run_w && tcnt_w == '0 && !armed_w));

  p_gain_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_n |=> $stable(gain_out));

  p_first_pix_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && row_idx == '0 && col_idx == '0) |-> (tcnt_w == TW'(FIRST)));

  p_col_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && start_n && !pwr_save && col_idx != CW'(COLS - 1))
      |=> (!start_n || (pix_valid && col_idx == $past(col_idx) + 1'b1)));

  p_row_adv_col0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    row_adv |-> (col_adv && col_idx == '0));

  p_row_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    row_last |-> (row_adv && row_idx == RW'(ROWS - 1)));

  p_col_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> (col_adv && col_idx == CW'(COLS - 1)));

  p_counters_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && tcnt_w == TW'(FRAME - 1))
      |-> (armed_w && slot_w == SW'(SLOTS - 1) && off_w == OW'(LINE - 1)));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !run_w);

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_save |-> !(row_adv || col_adv || col_last || row_last || frame_done));

  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_n && pwr_save) |=> (tcnt_w == $past(tcnt_w) && off_w == $past(off_w)));

endmodule

bind scan_tgen sg_scan_chk #(
  .COLS(COLS), .ROWS(ROWS), .READ_CLKS(READ_CLKS), .LEAD_SLOTS(LEAD_SLOTS),
  .GAIN_W(GAIN_W), .TW(TW), .OW(OW), .SW(SW), .RW(RW), .CW(CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_n    (start_n),
  .pwr_save   (pwr_save),
  .row_adv    (row_adv),
  .col_adv    (col_adv),
  .pix_valid  (pix_valid),
  .row_idx    (row_idx),
  .col_idx    (col_idx),
  .gain_out   (gain_out),
  .row_last   (row_last),
  .col_last   (col_last),
  .frame_done (frame_done),
  .run_w      (run_w),
  .tcnt_w     (tcnt_w),
  .armed_w    (armed_w),
  .off_w      (off_w),
  .slot_w     (slot_w)
);

// File: tb/sim_scan_tgen.sv
module sim_scan_tgen;

  localparam int COLS  = 192;
  localparam int ROWS  = 128;
  localparam int LINE  = COLS + 64;
  localparam int FIRST = 2 * LINE + 1;
  localparam int FRAME = FIRST + ROWS * LINE;
  localparam int WDOG  = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_n = 1'b1;
  logic       pwr_save = 1'b0;
  logic [2:0] gain_in = 3'd0;
  logic       row_adv, col_adv, sense_ph, pix_valid, row_last, col_last, frame_done;
  logic [6:0] row_idx;
  logic [7:0] col_idx;
  logic [2:0] gain_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_n = 0;
  bit ended = 0;

  // bench model state
  bit m_run = 0;
  int m_t = 0;
  int m_gain = 0;

  always #5 clk = ~clk;

  scan_tgen u0 (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .pwr_save(pwr_save),
    .gain_in(gain_in), .row_adv(row_adv), .col_adv(col_adv), .sense_ph(sense_ph),
    .pix_valid(pix_valid), .row_idx(row_idx), .col_idx(col_idx), .gain_out(gain_out),
    .row_last(row_last), .col_last(col_last), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (frame clock %0d)",
               req, what, act, exp, m_t);
    end
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n == WDOG && !ended) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_n);
      wrap_up();
    end
  end

  // expected outputs from the schedule in the requirements
  task automatic compare();
    int u, s, o;
    bit e_pv, e_sense, e_cadv, e_radv, e_clast, e_rlast, e_done;
    int e_row, e_col;
    string stb_req;
    e_pv = 0; e_sense = 0; e_cadv = 0; e_radv = 0;
    e_clast = 0; e_rlast = 0; e_done = 0; e_row = 0; e_col = 0;
    if (m_run && start_n && m_t > 0) begin
      u = m_t - 1;
      s = u / LINE;
      o = u % LINE;
      e_sense = (o >= COLS);
      if (s >= 2 && s < 2 + ROWS && o < COLS) begin
        e_pv = 1; e_row = s - 2; e_col = o;
      end
      if (!pwr_save) begin
        e_cadv  = e_pv;
        e_radv  = e_pv && o == 0;
        e_clast = e_pv && o == COLS - 1;
        e_rlast = e_radv && e_row == ROWS - 1;
        e_done  = (m_t == FRAME - 1);
      end
    end
    stb_req = pwr_save ? "R10" : "R7";
    chk(pix_valid == e_pv && int'(row_idx) == e_row && int'(col_idx) == e_col, "R5",
        "pixel {valid,row,col}",
        int'(pix_valid) * 100000 + int'(row_idx) * 1000 + int'(col_idx),
        int'(e_pv) * 100000 + e_row * 1000 + e_col);
    chk(sense_ph == e_sense, "R6", "sense_ph", int'(sense_ph), int'(e_sense));
    chk(col_adv == e_cadv && row_adv == e_radv, stb_req, "{col_adv,row_adv}",
        int'({col_adv, row_adv}), int'({e_cadv, e_radv}));
    chk(col_last == e_clast && row_last == e_rlast, "R8", "{col_last,row_last}",
        int'({col_last, row_last}), int'({e_clast, e_rlast}));
    chk(frame_done == e_done, "R9", "frame_done", int'(frame_done), int'(e_done));
    chk(int'(gain_out) == m_gain, "R3", "gain_out", int'(gain_out), m_gain);
    if (m_run && start_n && !pwr_save && m_t == FIRST)
      chk(pix_valid && row_idx == 0 && col_idx == 0, "R4", "first pixel valid",
          int'(pix_valid), 1);
    if (m_run && start_n && m_t == FIRST - 1)
      chk(!pix_valid, "R4", "no pixel before 513", int'(pix_valid), 0);
  endtask

  task automatic cyc(input logic sn, input logic ps, input logic [2:0] g);
    start_n = sn; pwr_save = ps; gain_in = g;
    @(posedge clk);
    if (!sn) begin
      m_run = 1; m_t = 0; m_gain = int'(g);
    end else if (!ps && m_run) begin
      if (m_t == FRAME - 1) begin m_run = 0; m_t = 0; end
      else m_t++;
    end
    @(negedge clk); #1;
    compare();
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    // reset state (R1)
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk({row_adv, col_adv, sense_ph, pix_valid, row_last, col_last, frame_done} == 7'b0
        && row_idx == 0 && col_idx == 0 && gain_out == 0, "R1", "outputs in reset",
        int'({row_adv, col_adv, sense_ph, pix_valid, row_last, col_last, frame_done}), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 3'($urandom));
    chk(!pix_valid && gain_out == 0, "R1", "idle after reset", int'(gain_out), 0);

    // plain frame, gain_in scrambled throughout (R2, R3, R4..R9)
    cyc(1'b0, 1'b0, 3'd5);
    chk(!pix_valid && !sense_ph && !col_adv, "R2", "quiet while start low",
        int'({pix_valid, sense_ph, col_adv}), 0);
    chk(gain_out == 3'd5, "R3", "gain latched at start", int'(gain_out), 5);
    for (int i = 0; i < FRAME; i++) cyc(1'b1, 1'b0, 3'($urandom));
    chk(!m_run, "R9", "model idle after frame length", int'(m_run), 0);
    for (int i = 0; i < 200; i++) cyc(1'b1, 1'b0, 3'($urandom));
    chk(!pix_valid && !sense_ph, "R9", "idle after frame", int'(pix_valid), 0);

    // frame with random power-save bursts (R10)
    cyc(1'b0, 1'b0, 3'd2);
    while (m_run && cyc_n < WDOG - 20000) cyc(1'b1, ($urandom % 8) == 0, 3'($urandom));

    // restart in the middle of a frame (R11)
    cyc(1'b0, 1'b0, 3'd6);
    for (int i = 0; i < 1000; i++) cyc(1'b1, 1'b0, 3'd0);
    cyc(1'b0, 1'b0, 3'd1);
    chk(m_t == 0 && !pix_valid, "R11", "restart clears", int'(pix_valid), 0);
    while (m_t < FIRST) cyc(1'b1, 1'b0, 3'd7);
    chk(pix_valid && row_idx == 0 && col_idx == 0 && gain_out == 3'd1, "R11",
        "first pixel after restart", int'({pix_valid, gain_out}), int'({1'b1, 3'd1}));

    // start while frozen (R12)
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 3'd0);
    cyc(1'b0, 1'b1, 3'd4);
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 3'd0);
    chk(gain_out == 3'd4 && !pix_valid && !sense_ph, "R12", "start honoured in power-save",
        int'(gain_out), 4);
    while (m_t < FIRST) cyc(1'b1, 1'b0, 3'd3);
    chk(pix_valid && row_idx == 0 && col_idx == 0, "R12", "first pixel after frozen start",
        int'(pix_valid), 1);
    for (int i = 0; i < 2 * LINE; i++) cyc(1'b1, 1'b0, 3'd0);
    chk(pix_valid && row_idx == 2 && col_idx == 0, "R5", "third row start",
        int'(row_idx) * 1000 + int'(col_idx), 2000);

    wrap_up();
  end

endmodule